// File: doc/BRIEF.md
# Integer Twin Butterfly Rounding Multiplier

This block is a datapath that computes both halves of a transform butterfly in one step. It takes two signed operands `a` and `b`, one signed coefficient `coef` shared by both halves, and a shift amount `shamt`. It returns `((a+b)*coef)` and `((a-b)*coef)`, each scaled down by `2^shamt` with round-to-nearest, ties toward positive infinity. The sum half drives `sum_res`, which is intended for the primary destination register. The difference half drives `diff_res`, which is intended for the register one index above it.

Typical use is in integer DCT, DFT and FFT kernels, for example a 32-bit datapath with a shift of 14. To get a two-coefficient butterfly, issue the block once with a shift of zero, then add or subtract a correction product and shift in a separate step. The `REGOUT` parameter selects the timing. With `REGOUT=1` there is one output register stage. With `REGOUT=0` the path is purely combinational.

Top module: `twin_butterfly_rnd`

## Requirements
- R1: Both operands are sign-extended by one bit before the add and subtract, so `a+b` and `a-b` never overflow. For example, a=b=0x7FFFFFFF, coef=1, shamt=1 gives sum_res=0x7FFFFFFF.
- R2: The sum and the difference are each multiplied as signed values by the same `coef`. When b=0, sum_res equals diff_res.
- R3: For shamt greater than 0, each result is (product + 2^(shamt-1)) arithmetically shifted right by shamt. For example, a product of -3 with shamt=1 gives -1, and a product of 3 with shamt=1 gives 2.
- R4: For shamt=0, each result is the low XLEN bits of its product, with no rounding term added.
- R5: Each result is the low XLEN bits of the rounded, shifted value, with no saturation. Values that overflow wrap.
- R6: With REGOUT=1, out_valid rises the cycle after in_valid is sampled high and falls the cycle after in_valid is sampled low. With REGOUT=0, out_valid equals in_valid in the same cycle, and the results follow the inputs combinationally.
- R7: With REGOUT=1, sum_res and diff_res keep their values across any cycle in which in_valid is low.
- R8: With REGOUT=1, an active-low reset clears out_valid, sum_res and diff_res to zero.
- R9: Every shift amount from 0 to XLEN-1 is supported, including the largest one, 31 at XLEN=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid |
| a | input | XLEN | Signed first operand |
| b | input | XLEN | Signed second operand |
| coef | input | XLEN | Signed shared coefficient |
| shamt | input | $clog2(XLEN) | Right shift amount with rounding |
| out_valid | output | 1 | Results valid |
| sum_res | output | XLEN | Rounded scaled (a+b)*coef, for the primary destination |
| diff_res | output | XLEN | Rounded scaled (a-b)*coef, for the paired destination |

## Verification
The bench runs several directed cases before the random ones:
- Extreme equal operands with a shift of one separate a widened sum from a wrapped one.
- Products of +3 and -3 with a shift of one show whether rounding ties go upward on the signed value.
- A zero shift with extreme operands exposes any rounding term leaking in, and any saturation where the result should wrap.

Random operands then sweep every shift from 0 to 31 and compare against a 96-bit reference. This catches wrong slice positions and wrong rounding positions. A zero `b` and the held-input cycles separate the shared coefficient path and the hold behaviour from the arithmetic.

// File: rtl/twin_butterfly_rnd.sv
module twin_butterfly_rnd #(
  parameter int XLEN   = 32,
  parameter bit REGOUT = 1'b1,
  localparam int SHW   = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] coef,
  input  logic [SHW-1:0]  shamt,
  output logic            out_valid,
  output logic [XLEN-1:0] sum_res,
  output logic [XLEN-1:0] diff_res
);
  localparam int PW = 2*XLEN + 2;

  logic [XLEN:0] wsum, wdif;
  assign wsum = {a[XLEN-1], a} + {b[XLEN-1], b};
  assign wdif = {a[XLEN-1], a} - {b[XLEN-1], b};

  logic [PW-1:0] cext, psum, pdif, rnd;
  assign cext = {{(PW-XLEN){coef[XLEN-1]}}, coef};
  assign psum = {{(PW-XLEN-1){wsum[XLEN]}}, wsum} * cext;
  assign pdif = {{(PW-XLEN-1){wdif[XLEN]}}, wdif} * cext;

  assign rnd = ({{(PW-1){1'b0}}, 1'b1} << shamt) >> 1;

  logic signed [PW-1:0] tsum, tdif, ssum, sdif;
  assign tsum = $signed(psum + rnd);
  assign tdif = $signed(pdif + rnd);
  assign ssum = tsum >>> shamt;
  assign sdif = tdif >>> shamt;

  logic [XLEN-1:0] nsum, ndif;
  assign nsum = ssum[XLEN-1:0];
  assign ndif = sdif[XLEN-1:0];

  generate
    if (REGOUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          sum_res   <= '0;
          diff_res  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            sum_res  <= nsum;
            diff_res <= ndif;
          end
        end
      end

      logic [XLEN-1:0] twice_ac;
      assign twice_ac = (a * coef) << 1;

      AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6
      AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_res) && $stable(diff_res))); // R7
      AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && b == '0) |=> (sum_res == diff_res)); // R2
      AST_NOSHIFT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == '0) |=> (XLEN'(sum_res + diff_res) == $past(twice_ac))); // R4
    end else begin : g_comb
      assign out_valid = in_valid;
      assign sum_res   = nsum;
      assign diff_res  = ndif;
    end
  endgenerate
endmodule

// File: tb/sim_twin_butterfly_rnd.sv
module sim_twin_butterfly_rnd;
  localparam int XLEN = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [XLEN-1:0] a = '0, b = '0, coef = '0;
  logic [4:0] shamt = '0;
  logic ov0, ov1;
  logic [XLEN-1:0] s0, d0, s1, d1;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twin_butterfly_rnd #(.XLEN(XLEN), .REGOUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .coef(coef),
    .shamt(shamt), .out_valid(ov0), .sum_res(s0), .diff_res(d0));
  twin_butterfly_rnd #(.XLEN(XLEN), .REGOUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .coef(coef),
    .shamt(shamt), .out_valid(ov1), .sum_res(s1), .diff_res(d1));

  function automatic logic [31:0] ref_res(input int ia, input int ib, input int ic,
                                          input int n, input bit dif);
    logic signed [95:0] x, y, p;
    x = ia;
    y = ib;
    p = (dif ? (x - y) : (x + y)) * 96'(signed'(ic));
    if (n > 0) p = p + (96'sd1 <<< (n - 1));
    p = p >>> n;
    return p[31:0];
  endfunction

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input int ia, input int ib, input int ic, input int n, input string tag);
    logic [31:0] es, ed;
    @(negedge clk);
    a = ia; b = ib; coef = ic; shamt = n[4:0]; in_valid = 1'b1;
    es = ref_res(ia, ib, ic, n, 1'b0);
    ed = ref_res(ia, ib, ic, n, 1'b1);
    #1;
    cmp({31'd0, ov1}, 32'd1, {tag, " R6 comb valid"});
    cmp(s1, es, {tag, " comb sum"});
    cmp(d1, ed, {tag, " comb diff"});
    @(negedge clk);
    cmp({31'd0, ov0}, 32'd1, {tag, " R6 reg valid"});
    cmp(s0, es, {tag, " sum"});
    cmp(d0, ed, {tag, " diff"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] hs, hd;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    cmp({31'd0, ov0}, 32'd0, "R8 reset valid");
    cmp(s0, 32'd0, "R8 reset sum");
    cmp(d0, 32'd0, "R8 reset diff");
    rst_n = 1'b1;

    apply(32'h7FFFFFFF, 32'h7FFFFFFF, 1, 1, "R1 widened sum");
    cmp(s0, 32'h7FFFFFFF, "R1 direct value");
    apply(-32'sd3, 0, 1, 1, "R3 neg tie");
    cmp(s0, 32'hFFFFFFFF, "R3 neg tie value");
    apply(3, 0, 1, 1, "R3 pos tie");
    cmp(s0, 32'd2, "R3 pos tie value");
    apply(1234, 0, -32'sd77, 9, "R2 zero b");
    cmp(s0, d0, "R2 equal halves");
    apply(32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, "R4 R5 no shift wrap");
    apply(-32'sd5, 3, 7, 0, "R4 small no shift");
    apply(32'h80000000, 32'h7FFFFFFF, 32'h80000000, 31, "R9 max shift");
    apply(12000, -9000, 11585, 14, "R3 typical shift 14");

    @(negedge clk);
    in_valid = 1'b0;
    hs = s0; hd = d0;
    a = 32'h1357; b = 32'h2468; coef = 32'h55; shamt = 5'd3;
    #1;
    cmp({31'd0, ov1}, 32'd0, "R6 comb valid low");
    @(negedge clk);
    cmp({31'd0, ov0}, 32'd0, "R6 reg valid low");
    @(negedge clk);
    cmp(s0, hs, "R7 hold sum");
    cmp(d0, hd, "R7 hold diff");

    for (int i = 0; i < 640; i++) begin
      int ra, rb, rc;
      ra = $urandom; rb = $urandom; rc = $urandom;
      if (i % 5 == 0) rc = $signed(rc) >>> 16;
      apply(ra, rb, rc, i % 32, "R3 R4 R5 R9 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule